// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave-only controller for a two-wire serial bus, placed in front of a 256-byte memory held in a register array. A system clock oversamples the bus clock (SCL) and data (SDA) lines. From these samples the block detects start and stop conditions and moves bytes in and out. The bus master always generates SCL and starts every transfer. The block pulls SDA low through an output enable and otherwise leaves the line to the pull-up.

A transfer begins with a device-select byte. Its upper four bits are the fixed code 1010, the next three bits must equal the strap inputs, and bit 0 selects read (1) or write (0). A write transfer carries a word-address byte, which loads the address counter, followed by up to four data bytes. These go into a page buffer, and the buffer is committed only when a stop ends the transfer. The commit runs for a fixed number of system clocks. During that time the block does not answer its device address. A read transfer returns bytes starting at the counter and advances the counter by one after each byte. The master acknowledges every byte it wants to continue with, and ends the read with a missing acknowledge followed by a stop.

The control FSM has these states. ST_IDLE waits for a start. ST_DEVSEL shifts in the device-select byte. ST_WADDR shifts in the word address. ST_WDATA shifts in write data. ST_ACK holds SDA low for the acknowledge clock. ST_RDATA shifts a byte out. ST_RACK samples the master's acknowledge. The transitions are:
- Start, from any state, goes to ST_DEVSEL.
- Stop, from any state, goes to ST_IDLE.
- In ST_DEVSEL, a matching byte with no commit in progress goes to ST_ACK; otherwise the FSM goes to ST_IDLE.
- ST_WADDR and ST_WDATA go to ST_ACK after eight bits.
- ST_ACK goes on the next SCL fall to its saved successor: ST_WADDR, ST_WDATA or ST_RDATA.
- ST_RDATA goes to ST_RACK after eight bits.
- ST_RACK goes back to ST_RDATA if the master acknowledged, and to ST_IDLE if it did not.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the output enable is low. Bus activity that is not preceded by a start condition (SDA falling while SCL is high) gets no acknowledge.
- R2: A device-select byte is accepted only when bits 7..4 equal 4'b1010 and bits 3..1 equal strap_i. Bit 0 chooses read (1) or write (0). Any other byte gets no acknowledge, and the block then ignores the bus until the next start.
- R3: For every accepted byte (device select, word address, write data) the block pulls SDA low during the ninth SCL clock, and releases it after that clock falls.
- R4: The block only pulls SDA low or releases it. Its output enable changes only after an SCL fall, or when a start or stop releases the line.
- R5: The word-address byte of a write transfer loads the 8-bit address counter.
- R6: In a page write, the data bytes go to consecutive addresses. Only the low two address bits advance, wrapping inside the aligned four-byte page, and the upper six bits stay fixed. A fifth byte overwrites the first.
- R7: Buffered write data is committed only when a stop ends the transfer. A repeated start discards the buffer and starts no commit.
- R8: For WRITE_CYCLES system clocks after a committing stop, the block does not acknowledge its device address. After that period the committed bytes can be read back.
- R9: A read sends the byte at the counter, most significant bit first, and advances the full 8-bit counter after each byte, rolling over from 255 to 0. A master acknowledge continues the read; a missing acknowledge returns the block to idle.
- R10: A start in the middle of a transfer restarts device selection while keeping the address counter. A stop always returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| strap_i | input | STRAP_W | Strap inputs giving the low device-address bits |
| sda_oe_o | output | 1 | High pulls SDA low; low releases the line |

## Verification
A wrong FSM state shows up within one bus clock, as a missing or extra acknowledge or as SDA driven during a bit the master owns. A bad address counter or page-wrap path stays hidden until the data is read back. It then appears as a wrong byte, at the page boundary or at the 255-to-0 rollover. A commit timer that is stuck or ends early shows up as an acknowledge or a refusal in the device-select byte sent straight after the committing stop. Discarded or committed buffers are checked by reading back known earlier contents.

// File: rtl/twi_mem_pkg.sv
`timescale 1ns/1ps
package twi_mem_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int DEV_W  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } twi_state_e;
endpackage

// File: rtl/twi_bus_sync.sv
`timescale 1ns/1ps
module twi_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[STAGES-1];
    assign scl_old = scl_pipe[STAGES];
    assign sda_now = sda_pipe[STAGES-1];
    assign sda_old = sda_pipe[STAGES];

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/twi_commit_timer.sv
`timescale 1ns/1ps
module twi_commit_timer #(
    parameter int CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i && cnt_q == '0)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/twi_mem_array.sv
`timescale 1ns/1ps
module twi_mem_array
    import twi_mem_pkg::*;
#(
    parameter int PAGE_BYTES = 4
) (
    input  logic                              clk,
    input  logic                              we_i,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_i,
    input  logic [PAGE_BYTES-1:0]             mask_i,
    input  logic [PAGE_BYTES-1:0][BYTE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]                 raddr_i,
    output logic [BYTE_W-1:0]                 rdata_o
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int DEPTH  = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask_i[i])
                    mem[{page_i, PAGE_W'(i)}] <= wdata_i[i];
            end
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/twi_mem_slave.sv
`timescale 1ns/1ps
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int               PAGE_BYTES   = 4,
    parameter int               WRITE_CYCLES = 1_000_000,
    parameter int               SYNC_STAGES  = 2,
    parameter int               STRAP_W      = 3,
    parameter logic [DEV_W-1:0] DEV_BASE     = 7'b1010000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    twi_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    twi_state_e state_q, state_d, after_ack_q;
    logic [BYTE_W-1:0]                 shreg_q;
    logic [3:0]                        bitcnt_q;
    logic [ADDR_W-1:0]                 addr_q;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] pbuf_q;
    logic [PAGE_BYTES-1:0]             pmask_q, cmask_q;
    logic                              rd_more_q;
    logic                              busy, commit_done, commit_go;
    logic [BYTE_W-1:0]                 rdata;
    logic                              byte_done, dev_hit;

    assign commit_go = bus_stop && (|pmask_q) && !busy;

    twi_commit_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(commit_go),
        .busy_o(busy), .done_o(commit_done)
    );

    twi_mem_array #(.PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .we_i(commit_done), .page_i(addr_q[ADDR_W-1:PAGE_W]),
        .mask_i(cmask_q), .wdata_i(pbuf_q), .raddr_i(addr_q), .rdata_o(rdata)
    );

    assign byte_done = scl_fall && (bitcnt_q == 4'd8);
    assign dev_hit   = (shreg_q[BYTE_W-1:STRAP_W+1] == DEV_BASE[DEV_W-1:STRAP_W])
                    && (shreg_q[STRAP_W:1] == strap_i) && !busy;

    // next state
    always_comb begin
        state_d = state_q;
        if (bus_stop)
            state_d = ST_IDLE;
        else if (bus_start)
            state_d = ST_DEVSEL;
        else begin
            unique case (state_q)
                ST_IDLE:            state_d = ST_IDLE;
                ST_DEVSEL:          if (byte_done) state_d = dev_hit ? ST_ACK : ST_IDLE;
                ST_WADDR, ST_WDATA: if (byte_done) state_d = ST_ACK;
                ST_ACK:             if (scl_fall) state_d = after_ack_q;
                ST_RDATA:           if (scl_fall && bitcnt_q == 4'd7) state_d = ST_RACK;
                ST_RACK:            if (scl_fall) state_d = rd_more_q ? ST_RDATA : ST_IDLE;
                default:            state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            after_ack_q <= ST_IDLE;
            shreg_q     <= '0;
            bitcnt_q    <= '0;
            addr_q      <= '0;
            pbuf_q      <= '0;
            pmask_q     <= '0;
            cmask_q     <= '0;
            rd_more_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (commit_go)
                cmask_q <= pmask_q;
            if (bus_start || bus_stop) begin
                bitcnt_q <= '0;
                pmask_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_DEVSEL, ST_WADDR, ST_WDATA: begin
                        if (scl_rise && bitcnt_q != 4'd8) begin
                            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end
                        if (byte_done) begin
                            bitcnt_q <= '0;
                            if (state_q == ST_DEVSEL) begin
                                after_ack_q <= shreg_q[0] ? ST_RDATA : ST_WADDR;
                            end else if (state_q == ST_WADDR) begin
                                addr_q      <= shreg_q;
                                after_ack_q <= ST_WDATA;
                            end else begin
                                pbuf_q[addr_q[PAGE_W-1:0]]  <= shreg_q;
                                pmask_q[addr_q[PAGE_W-1:0]] <= 1'b1;
                                addr_q[PAGE_W-1:0]          <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
                                after_ack_q                 <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (after_ack_q == ST_RDATA) begin
                                shreg_q <= rdata;
                                addr_q  <= addr_q + ADDR_W'(1);
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt_q == 4'd7) begin
                                bitcnt_q <= '0;
                            end else begin
                                shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                                bitcnt_q <= bitcnt_q + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise)
                            rd_more_q <= ~sda_s;
                        if (scl_fall && rd_more_q) begin
                            shreg_q <= rdata;
                            addr_q  <= addr_q + ADDR_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = (state_q == ST_ACK) || (state_q == ST_RDATA && !shreg_q[BYTE_W-1]);
    end
endmodule

// File: rtl/twi_mem_slave_chk.sv
`timescale 1ns/1ps
module twi_mem_slave_chk
    import twi_mem_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_fall,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              busy,
    input logic              byte_done,
    input twi_state_e        state,
    input logic [ADDR_W-1:0] addr
);
    a_r4_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));

    a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (state == ST_IDLE && !sda_oe));

    a_r10_start_to_devsel: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> (state == ST_DEVSEL));

    a_r8_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEVSEL && byte_done && busy && !bus_start && !bus_stop) |=> (state == ST_IDLE));

    a_r7_commit_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop));

    a_r6_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && $past(state == ST_WDATA)) |-> $stable(addr[ADDR_W-1:PAGE_W]));
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .busy(busy),
    .byte_done(byte_done), .state(state_q), .addr(addr_q)
);

// File: tb/twi_mem_slave_tb.sv
`timescale 1ns/1ps
module twi_mem_slave_tb;
    localparam int WCYC = 300;
    localparam int H    = 10;
    localparam logic [7:0] DEV_WR = 8'hAA;
    localparam logic [7:0] DEV_RD = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    always #2.5 clk = ~clk;
    assign sda_line = !(sda_oe || m_low);

    twi_mem_slave #(.WRITE_CYCLES(WCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .strap_i(3'b101), .sda_oe_o(sda_oe)
    );

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [7:0] obs_byte;
    event obs_ev;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_low = 1'b0; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_low = 1'b1; wclk(H);
        m_scl = 1'b0; wclk(2);
    endtask

    task automatic m_stop();
        m_low = 1'b1; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_low = 1'b0; wclk(H);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wclk(H);
            m_scl = 1'b1;  wclk(H);
            m_scl = 1'b0;  wclk(2);
        end
        m_low = 1'b0; wclk(H);
        m_scl = 1'b1; wclk(H/2);
        ack = sda_line;
        wclk(H/2);
        m_scl = 1'b0; wclk(2);
    endtask

    task automatic rbyte(input bit more, input bit check);
        logic [7:0] b;
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wclk(H);
            m_scl = 1'b1; wclk(H/2);
            b[i] = sda_line;
            wclk(H/2);
            m_scl = 1'b0; wclk(2);
        end
        if (check) begin
            obs_byte = b;
            ->obs_ev;
        end
        m_low = more; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_scl = 1'b0; wclk(2);
        m_low = 1'b0;
    endtask

    task automatic wr_page(input logic [7:0] a, input int n, input logic [7:0] d[5], input bit wait_commit);
        logic ack;
        m_start();
        wbyte(DEV_WR, ack); chk("R3 device select ack", ack, 0);
        wbyte(a, ack);      chk("R5 word address ack", ack, 0);
        for (int k = 0; k < n; k++) begin
            wbyte(d[k], ack); chk("R3 data ack", ack, 0);
        end
        m_stop();
        if (wait_commit) wclk(WCYC + 50);
    endtask

    task automatic rd_from(input logic [7:0] a, input int n);
        logic ack;
        m_start();
        wbyte(DEV_WR, ack); chk("R2 write select ack", ack, 0);
        wbyte(a, ack);      chk("R5 address load ack", ack, 0);
        m_start();
        wbyte(DEV_RD, ack); chk("R10 repeated start read select", ack, 0);
        for (int k = 0; k < n; k++) rbyte(k < n - 1, 1'b1);
        m_stop();
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                chk("R9 unexpected read byte", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, {24'h0, obs_byte}, {24'h0, e.val});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d[5];
        wclk(20);
        rst_n = 1'b1;
        wclk(10);
        chk("R1 released after reset", sda_oe, 0);

        // R1: a byte with no start before it
        m_scl = 1'b0; wclk(H);
        wbyte(DEV_WR, ack);
        chk("R1 no ack without start", ack, 1);

        // R2: strap mismatch
        m_start();
        wbyte(8'hA0, ack);
        chk("R2 wrong strap not acked", ack, 1);
        m_stop();

        // single write, then select during commit
        d = '{8'h5C, 8'h0, 8'h0, 8'h0, 8'h0};
        wr_page(8'h10, 1, d, 1'b0);
        m_start();
        wbyte(DEV_WR, ack);
        chk("R8 select refused while busy", ack, 1);
        m_stop();
        wclk(WCYC + 50);

        expect_byte(8'h5C, "R8 committed byte readable");
        rd_from(8'h10, 1);

        // page write with wrap; R6
        d = '{8'h99, 8'h0, 8'h0, 8'h0, 8'h0};
        wr_page(8'h48, 1, d, 1'b1);
        d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        wr_page(8'h46, 5, d, 1'b1);
        expect_byte(8'h33, "R6 wrapped byte at 0x44");
        expect_byte(8'h44, "R6 wrapped byte at 0x45");
        expect_byte(8'h55, "R6 fifth byte overwrote 0x46");
        expect_byte(8'h22, "R6 byte at 0x47");
        expect_byte(8'h99, "R9 read crosses page to 0x48");
        rd_from(8'h44, 5);

        // rollover and high bits fixed
        d = '{8'hEE, 8'h01, 8'h0, 8'h0, 8'h0};
        wr_page(8'hFF, 2, d, 1'b1);
        d = '{8'h77, 8'h0, 8'h0, 8'h0, 8'h0};
        wr_page(8'h00, 1, d, 1'b1);
        expect_byte(8'hEE, "R9 byte at 0xFF");
        expect_byte(8'h77, "R9 counter rolls to 0x00");
        rd_from(8'hFF, 2);
        expect_byte(8'h01, "R6 write wrapped to 0xFC");
        rd_from(8'hFC, 1);

        // R7: repeated start discards the buffer
        d = '{8'h12, 8'h0, 8'h0, 8'h0, 8'h0};
        wr_page(8'h30, 1, d, 1'b1);
        m_start();
        wbyte(DEV_WR, ack); chk("R3 select ack", ack, 0);
        wbyte(8'h30, ack);  chk("R5 address ack", ack, 0);
        wbyte(8'hAB, ack);  chk("R3 data ack", ack, 0);
        m_start();
        wbyte(DEV_RD, ack);
        chk("R7 no commit after repeated start", ack, 0);
        rbyte(1'b0, 1'b0);
        m_stop();
        wclk(20);
        chk("R9 line released after nak and stop", sda_oe, 0);
        expect_byte(8'h12, "R7 discarded write left old data");
        rd_from(8'h30, 1);

        wclk(50);
        chk("R9 all expected bytes seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule